// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Selectable Read Latency

This block is a synthesizable behavioural model of a synchronous burst static RAM. It is organised as words of two 9-bit bytes and has a small, parameterized depth for simulation. Every command, address, write strobe and write data word is captured on the rising clock edge. Output enable and sleep act at once, without waiting for a clock edge.

A strap input is sampled during reset and fixes the read latency. In flow-through mode, read data appears in the same cycle the read command is captured. In pipelined mode, the data passes through an output register and appears one cycle later. A second strap, also sampled during reset, picks the order of the 2-bit burst counter: linear wrap-around or XOR-interleaved.

A burst can start from either of two address strobes. The processor strobe always begins with a read. The controller strobe begins with a read or a write, as the write strobes decide. Later words of the burst follow the internal counter, which steps only when the advance input is asserted. Deselect uses single-cycle timing: in pipelined mode, the edge that captures a deselect also switches the outputs off. A sleep input freezes the device and keeps the array contents. The bidirectional data bus is modelled as an input word, an output word and an output-enable flag.

Top module: `burst_sram`

## Requirements
- R1: While `rstN` is low at a clock edge, the edge clears every pending read, so `dOutEn` is 0 and `dOut` is 0 after it.
- R2: With `pipeStrap` low during reset (flow-through), a read captured at edge k drives `dOut` with the addressed word and raises `dOutEn` in the cycle right after edge k.
- R3: With `pipeStrap` high during reset (pipelined), a read captured at edge k gives no output after edge k and drives the word after edge k+1.
- R4: With `gwN` high and `bweN` low, a write stores only the bytes whose `byteWrN` bit is 0. Bit 0 selects `dIn[8:0]` and bit 1 selects `dIn[17:9]`. With both `gwN` and `bweN` high, nothing is written.
- R5: `gwN` low writes both bytes, whatever the values of `bweN` and `byteWrN`.
- R6: A burst started by `adspN` low (with `ceN` low) is always a read, and the write strobes are ignored in that cycle.
- R7: On a continuation cycle (`adspN` and `adscN` high, device selected) with `advN` low, the 2-bit counter steps, and the low two address bits become base+n mod 4 when `linStrap` was high in reset, or base XOR n when it was low. Writes follow the same sequence.
- R8: A continuation cycle with `advN` high repeats the current burst address.
- R9: A deselect (`ceN` high with `adspN` or `adscN` low) captured at an edge leaves `dOutEn` at 0 after that edge. This holds in pipelined mode even when a read was captured one edge earlier.
- R10: `oeN` high forces `dOutEn` low immediately, without a clock edge. Lowering it again brings back the pending output.
- R11: While `sleep` is high, `dOutEn` is 0 at once and captured commands (including writes) are ignored. The stored data is kept, and operation resumes at the first edge after `sleep` falls.
- R12: A new start address may be given on every cycle, and each read yields its own word in consecutive cycles.
- R13: The straps are taken only while `rstN` is low. Changing them afterwards does not change the read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while low |
| pipeStrap | input | 1 | 1 = registered-output reads, 0 = flow-through reads |
| linStrap | input | 1 | 1 = linear burst order, 0 = interleaved order |
| ceN | input | 1 | Active-low chip enable |
| adspN | input | 1 | Active-low processor address strobe (read start) |
| adscN | input | 1 | Active-low controller address strobe (read or write start) |
| advN | input | 1 | Active-low burst advance |
| gwN | input | 1 | Active-low global write, all bytes |
| bweN | input | 1 | Active-low byte-write enable |
| byteWrN | input | 2 | Active-low per-byte write strobes |
| addr | input | ADDR_W | Word address |
| dIn | input | 18 | Write data |
| oeN | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dOut | output | 18 | Read data; 0 while not driven |
| dOutEn | output | 1 | High while the data bus would be driven |

## Verification
The properties take for granted that the straps are held at their intended values while reset is low, and that `oeN` and `sleep` never carry unknown values at a clock edge. They also assume that a device sleeping across an edge receives no command that matters. The stimulus drives every input between edges, one nanosecond after the rising edge, and changes `oeN` and `sleep` only in the middle of a cycle. It holds reset for several edges with the straps already settled. A sweep writes every word and reads it back in both latency modes, then runs bursts from every start offset in both counter orders. The remaining cases are the deselect and sleep corners.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // bytes per word; fixed by the control strobe layout
  localparam int NUM_BYTES = 2;

  // per-edge strobes from control to datapath
  typedef struct packed {
    logic                 load;     // capture a new burst start address
    logic                 advance;  // step the burst counter
    logic                 rdEn;     // read access in this cycle
    logic [NUM_BYTES-1:0] wrBytes;  // byte lanes written in this cycle
    logic                 hold;     // device asleep at this edge
  } sramStrobes_t;

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pipeStrap,
  input  logic                 linStrap,
  input  logic                 ceN,
  input  logic                 adspN,
  input  logic                 adscN,
  input  logic                 advN,
  input  logic                 gwN,
  input  logic                 bweN,
  input  logic [NUM_BYTES-1:0] byteWrN,
  input  logic                 sleep,
  output sramStrobes_t         stb,
  output logic                 selQ,
  output logic                 modePipe,
  output logic                 modeLinear,
  output logic                 deselStb
);

  logic                 startCyc;
  logic                 deselCyc;
  logic                 contCyc;
  logic                 adspStart;
  logic [NUM_BYTES-1:0] wrReq;

  always_comb begin
    startCyc  = !sleep && !ceN && (!adspN || !adscN);
    deselCyc  = !sleep && ceN && (!adspN || !adscN);
    contCyc   = !sleep && !startCyc && !deselCyc && selQ;
    adspStart = startCyc && !adspN;

    // global write wins over the byte controls
    if (!gwN)       wrReq = '1;
    else if (!bweN) wrReq = ~byteWrN;
    else            wrReq = '0;

    stb.hold    = sleep;
    stb.load    = startCyc;
    stb.advance = contCyc && !advN;
    stb.wrBytes = ((startCyc && !adspStart) || contCyc) ? wrReq : '0;
    stb.rdEn    = (startCyc || contCyc) && (stb.wrBytes == '0);
    deselStb    = deselCyc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePipe   <= pipeStrap;
      modeLinear <= linStrap;
      selQ       <= 1'b0;
    end else if (startCyc) begin
      selQ <= 1'b1;
    end else if (deselCyc) begin
      selQ <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  sramStrobes_t                stb,
  input  logic                        modePipe,
  input  logic                        modeLinear,
  input  logic                        selQ,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W*NUM_BYTES-1:0] dIn,
  output logic [BYTE_W*NUM_BYTES-1:0] rdData,
  output logic                        driveQ
);

  localparam int DATA_W = BYTE_W * NUM_BYTES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0]  baseQ;
  logic [ADDR_W-1:0]  effAddr;
  logic [ADDR_W-1:0]  rdAddrQ;
  logic [BURST_W-1:0] cntQ;
  logic [BURST_W-1:0] cntNext;
  logic [BURST_W-1:0] lowBits;
  logic               rdValidQ;
  logic               outValidQ;
  logic [DATA_W-1:0]  outRegQ;
  logic [DATA_W-1:0]  arrayOut;

  // burst address generation
  always_comb begin
    cntNext = stb.advance ? cntQ + 1'b1 : cntQ;
    lowBits = modeLinear ? baseQ[BURST_W-1:0] + cntNext
                         : baseQ[BURST_W-1:0] ^ cntNext;
    effAddr = stb.load ? addr : {baseQ[ADDR_W-1:BURST_W], lowBits};
  end

  // byte-lane writes
  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (stb.wrBytes[b]) mem[effAddr][b*BYTE_W +: BYTE_W] <= dIn[b*BYTE_W +: BYTE_W];
    end
  end

  assign arrayOut = mem[rdAddrQ];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ     <= '0;
      cntQ      <= '0;
      rdAddrQ   <= '0;
      rdValidQ  <= 1'b0;
      outValidQ <= 1'b0;
      outRegQ   <= '0;
    end else begin
      if (stb.load) begin
        baseQ <= addr;
        cntQ  <= '0;
      end else begin
        cntQ <= cntNext;
      end
      if (stb.rdEn) rdAddrQ <= effAddr;
      rdValidQ  <= stb.rdEn;
      outRegQ   <= arrayOut;
      outValidQ <= rdValidQ && !stb.hold;
    end
  end

  // latency select: bypass or output register; deselect cuts the registered path
  always_comb begin
    if (modePipe) begin
      rdData = outRegQ;
      driveQ = outValidQ && selQ;
    end else begin
      rdData = arrayOut;
      driveQ = rdValidQ;
    end
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BYTE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pipeStrap,
  input  logic                        linStrap,
  input  logic                        ceN,
  input  logic                        adspN,
  input  logic                        adscN,
  input  logic                        advN,
  input  logic                        gwN,
  input  logic                        bweN,
  input  logic [NUM_BYTES-1:0]        byteWrN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W*NUM_BYTES-1:0] dIn,
  input  logic                        oeN,
  input  logic                        sleep,
  output logic [BYTE_W*NUM_BYTES-1:0] dOut,
  output logic                        dOutEn
);

  localparam int DATA_W = BYTE_W * NUM_BYTES;

  sramStrobes_t      stb;
  logic              selQ;
  logic              modePipe;
  logic              modeLinear;
  logic              deselStb;
  logic [DATA_W-1:0] rdData;
  logic              driveQ;

  burst_sram_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pipeStrap  (pipeStrap),
    .linStrap   (linStrap),
    .ceN        (ceN),
    .adspN      (adspN),
    .adscN      (adscN),
    .advN       (advN),
    .gwN        (gwN),
    .bweN       (bweN),
    .byteWrN    (byteWrN),
    .sleep      (sleep),
    .stb        (stb),
    .selQ       (selQ),
    .modePipe   (modePipe),
    .modeLinear (modeLinear),
    .deselStb   (deselStb)
  );

  burst_sram_dp #(
    .ADDR_W  (ADDR_W),
    .BYTE_W  (BYTE_W),
    .BURST_W (BURST_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .modePipe   (modePipe),
    .modeLinear (modeLinear),
    .selQ       (selQ),
    .addr       (addr),
    .dIn        (dIn),
    .rdData     (rdData),
    .driveQ     (driveQ)
  );

  // asynchronous output gating
  assign dOutEn = driveQ && !oeN && !sleep;
  assign dOut   = dOutEn ? rdData : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rstN,
  input logic oeN,
  input logic sleep,
  input logic dOutEn,
  input logic modePipe,
  input logic rdEn,
  input logic deselStb
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !dOutEn);

  // R10
  oe_gate_chk: assert property (@(posedge clk) oeN |-> !dOutEn);

  // R11
  sleep_gate_chk: assert property (@(posedge clk) sleep |-> !dOutEn);

  // R9
  scd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    deselStb |=> !dOutEn);

  // R2
  flow_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modePipe && rdEn) |=> (dOutEn || oeN || sleep));

  // R3
  pipe_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modePipe && rdEn) ##1 (!deselStb && !sleep) |=> (dOutEn || oeN || sleep));

  // R13
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modePipe));

endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .oeN      (oeN),
  .sleep    (sleep),
  .dOutEn   (dOutEn),
  .modePipe (modePipe),
  .rdEn     (stb.rdEn),
  .deselStb (deselStb)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pipeStrap = 1'b0;
  logic        linStrap = 1'b1;
  logic        ceN = 1'b1;
  logic        adspN = 1'b1;
  logic        adscN = 1'b1;
  logic        advN = 1'b1;
  logic        gwN = 1'b1;
  logic        bweN = 1'b1;
  logic [1:0]  byteWrN = 2'b11;
  logic [5:0]  addr = '0;
  logic [17:0] dIn = '0;
  logic        oeN = 1'b0;
  logic        sleep = 1'b0;
  logic [17:0] dOut;
  logic        dOutEn;

  int checks = 0;
  int failures = 0;
  logic [17:0] model [64];

  always #2 clk = ~clk;

  burst_sram u0 (
    .clk(clk), .rstN(rstN), .pipeStrap(pipeStrap), .linStrap(linStrap),
    .ceN(ceN), .adspN(adspN), .adscN(adscN), .advN(advN), .gwN(gwN),
    .bweN(bweN), .byteWrN(byteWrN), .addr(addr), .dIn(dIn), .oeN(oeN),
    .sleep(sleep), .dOut(dOut), .dOutEn(dOutEn)
  );

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 1031 + 341) % 262144);
  endfunction

  task automatic chkVal(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // apply one command, let the edge capture it, return 1 ns after the edge
  task automatic drive(input logic ce, input logic adsp, input logic adsc, input logic adv,
                       input logic gw, input logic bwe, input logic [1:0] bw,
                       input int a, input logic [17:0] d);
    ceN = ce; adspN = adsp; adscN = adsc; advN = adv;
    gwN = gw; bweN = bwe; byteWrN = bw; addr = 6'(a); dIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic rdStart(input int a);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, a, '0);
  endtask

  task automatic wrStart(input int a, input logic [17:0] d);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'b11, a, d);
  endtask

  task automatic desel();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 0, '0);
  endtask

  task automatic contRd(input logic adv);
    drive(1'b0, 1'b1, 1'b1, adv, 1'b1, 1'b1, 2'b11, 0, '0);
  endtask

  task automatic contWr(input logic [17:0] d);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 0, d);
  endtask

  task automatic doReset(input logic pipe, input logic lin);
    rstN = 1'b0; pipeStrap = pipe; linStrap = lin;
    ceN = 1'b1; adspN = 1'b1; adscN = 1'b1; advN = 1'b1;
    gwN = 1'b1; bweN = 1'b1; byteWrN = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  function automatic int linAddr(input int base, input int n);
    return (base & ~3) | ((base + n) & 3);
  endfunction

  function automatic int ilvAddr(input int base, input int n);
    return (base & ~3) | ((base ^ n) & 3);
  endfunction

  initial begin
    #800000;
    failures++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // ---------------- flow-through, linear ----------------
    doReset(1'b0, 1'b1);
    chkBit("R1 dOutEn after reset", dOutEn, 1'b0);
    chkVal("R1 dOut after reset", dOut, '0);

    // R5: global write fills the array with byte controls inactive
    for (int a = 0; a < 64; a++) begin
      wrStart(a, pat(a));
      model[a] = pat(a);
    end
    desel();

    // R2 / R12: back-to-back flow-through reads
    for (int a = 0; a < 64; a++) begin
      rdStart(a);
      chkBit("R2 flow drive", dOutEn, 1'b1);
      chkVal("R12 flow data", dOut, model[a]);
    end

    // R5: global write with byte strobes also active on one lane only
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 3, 18'h2aaaa);
    model[3] = 18'h2aaaa;
    rdStart(3);
    chkVal("R5 global write overrides byte strobes", dOut, model[3]);

    // R4: byte-lane writes; bweN high for a >= 4 means no write
    for (int a = 0; a < 8; a++) begin
      logic [1:0]  m;
      logic [17:0] d;
      m = 2'(a);
      d = ~pat(a + 100);
      drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, (a >= 4), m, 8 + a, d);
      if (a < 4) begin
        if (!m[0]) model[8 + a][8:0]  = d[8:0];
        if (!m[1]) model[8 + a][17:9] = d[17:9];
      end
    end
    for (int a = 0; a < 8; a++) begin
      rdStart(8 + a);
      chkVal("R4 byte lanes", dOut, model[8 + a]);
    end

    // R6: processor-strobe start ignores write strobes
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 10, 18'h3ffff);
    chkVal("R6 adsp start reads", dOut, model[10]);
    rdStart(10);
    chkVal("R6 array unchanged", dOut, model[10]);

    // R7 / R8: linear bursts from every start offset
    for (int s = 0; s < 4; s++) begin
      int base;
      base = 16 + s;
      rdStart(base);
      chkVal("R7 linear first", dOut, model[base]);
      for (int n = 1; n < 4; n++) begin
        contRd(1'b0);
        chkVal("R7 linear step", dOut, model[linAddr(base, n)]);
      end
      contRd(1'b1);
      chkVal("R8 suspend repeats", dOut, model[linAddr(base, 3)]);
    end

    // R7: linear write burst
    wrStart(42, 18'h11111); model[42] = 18'h11111;
    contWr(18'h22222);      model[43] = 18'h22222;
    contWr(18'h33333);      model[40] = 18'h33333;
    contWr(18'h04444);      model[41] = 18'h04444;
    for (int a = 40; a < 44; a++) begin
      rdStart(a);
      chkVal("R7 write burst", dOut, model[a]);
    end

    // R10: asynchronous output enable
    rdStart(5);
    oeN = 1'b1;
    #1;
    chkBit("R10 oeN high", dOutEn, 1'b0);
    oeN = 1'b0;
    #1;
    chkBit("R10 oeN low again", dOutEn, 1'b1);
    chkVal("R10 data back", dOut, model[5]);

    // R11: sleep gates output and ignores a write
    rdStart(5);
    sleep = 1'b1;
    #1;
    chkBit("R11 sleep async off", dOutEn, 1'b0);
    wrStart(5, 18'h00000);
    chkBit("R11 sleep off after edge", dOutEn, 1'b0);
    sleep = 1'b0;
    rdStart(5);
    chkVal("R11 contents kept", dOut, model[5]);

    // R9 in flow mode
    desel();
    chkBit("R9 flow deselect", dOutEn, 1'b0);

    // ---------------- pipelined, interleaved ----------------
    doReset(1'b1, 1'b0);
    chkBit("R1 dOutEn after second reset", dOutEn, 1'b0);
    pipeStrap = 1'b0;  // R13: ignored after reset
    linStrap = 1'b1;
    desel();
    rdStart(0);
    chkBit("R3 no output after capture edge", dOutEn, 1'b0);
    for (int a = 1; a < 64; a++) begin
      rdStart(a);
      chkBit("R3 pipe drive", dOutEn, 1'b1);
      chkVal("R13 pipe data lags one cycle", dOut, model[a - 1]);
    end
    contRd(1'b1);
    chkVal("R12 pipe last word", dOut, model[63]);

    // R7: interleaved burst, one-cycle lag
    desel();
    rdStart(33);
    for (int n = 1; n < 4; n++) begin
      contRd(1'b0);
      chkVal("R7 interleave lagged", dOut, model[ilvAddr(33, n - 1)]);
    end
    contRd(1'b1);
    chkVal("R7 interleave last", dOut, model[ilvAddr(33, 3)]);
    contRd(1'b1);
    chkVal("R8 pipe suspend", dOut, model[ilvAddr(33, 3)]);

    // R9: deselect right after a read cuts the registered output
    rdStart(7);
    desel();
    chkBit("R9 single-cycle deselect", dOutEn, 1'b0);
    chkVal("R9 data off", dOut, '0);
    rdStart(7);
    contRd(1'b1);
    chkBit("R9 contrast held select", dOutEn, 1'b1);
    chkVal("R9 contrast data", dOut, model[7]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule